// File: doc/BRIEF.md
# Power-down standby gating controller

This block sits between the pins of a small programmable logic device and its logic core. It models a dedicated, active-high power-down pin. All windows run on a fast system clock, and each window is a parameter counted in system-clock cycles. When the power-down pin is sampled high, the controller captures the functional inputs and the output enable as they stand on that edge. From then on it presents those captured values to the core, so activity on the pins has no effect. It also forces the core clock low, so no core register can update.

When the pin is sampled low again, a single recovery counter starts. The functional inputs, the output enable, the core clock and the output-valid flag each go live again after their own number of cycles. The clock threshold is longer than the data thresholds. Once the longest window has run out, the controller is back in the active state. The power-down pin is never passed to the core as a data input. A power-down pulse that is too short, high or low, sets a sticky violation flag but does not change the sequence. There is no data stream here: all pins are plain levels, and the core-facing outputs are combinational selects of the live pins or of the held values.

Top module: `pd_standby_ctrl`

## Requirements
- R1: After reset the status reads ACTIVE (code 0), `out_valid` is 1 and `width_viol` is 0.
- R2: In ACTIVE, `core_in`, `core_oe` and `core_clk` equal `pin_in`, `pin_oe` and `pin_clk` in the same cycle. `pd_pin` does not appear in `core_in`.
- R3: The first clock edge that samples `pd_pin` high in ACTIVE moves the status to STANDBY (code 1). From then on, `core_in` and `core_oe` hold the values `pin_in` and `pin_oe` had at that edge and ignore later pin changes.
- R4: In STANDBY, `core_clk` is 0 and `out_valid` is 0, whatever `pin_clk` does.
- R5: The first edge that samples `pd_pin` low in STANDBY moves the status to RECOVERING (code 2). Call that edge the exit edge.
- R6: Counting edges after the exit edge, the inputs go live after IN_RECOV edges, the output enable after OE_RECOV, the core clock after CLK_RECOV and `out_valid` after OUT_RECOV. The defaults are 3, 3, 4 and 5. Before its threshold, each core-facing signal keeps its held value, or 0 for the clock and `out_valid`. All four thresholds are at least 1.
- R7: The status returns to ACTIVE when the largest of the four thresholds has elapsed after the exit edge, with `pd_pin` still low.
- R8: An edge that samples `pd_pin` high in RECOVERING returns the status to STANDBY. This takes precedence over completing recovery on that same edge. Signals already live hold their last live value.
- R9: `width_viol` sets when a high level of `pd_pin` lasted fewer than MIN_HIGH sampled cycles (default 4). It also sets when a low level that followed a high level lasted fewer than MIN_LOW cycles (default 4). The standby and recovery sequence proceeds unchanged.
- R10: `width_viol` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times every window |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_pin | input | 1 | Power-down request, active high |
| pin_in | input | N_IN | Functional inputs from the pins |
| pin_oe | input | 1 | Output enable from its pin |
| pin_clk | input | 1 | Device clock from its pin |
| core_in | output | N_IN | Inputs presented to the core |
| core_oe | output | 1 | Output enable presented to the core |
| core_clk | output | 1 | Gated clock to the core |
| out_valid | output | 1 | Core outputs may be trusted |
| pd_state | output | 2 | 0 ACTIVE, 1 STANDBY, 2 RECOVERING |
| width_viol | output | 1 | Sticky short-pulse flag |

## Verification
Two functions can fall on the same edge: recovery completing, and a fresh power-down request that sends the block back to standby. A directed case holds `pd_pin` low for exactly the recovery length and raises it on the edge where the counter would finish. The case is judged by the status reading STANDBY rather than ACTIVE, with `out_valid` still low, and by the held inputs being the last live ones. The width monitor can likewise flag a short pulse on the same edge as a state change. Random pulse lengths from one cycle upward produce many such coincidences, and each is compared cycle by cycle against a bench reference.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic [1:0] {
    PD_ACTIVE     = 2'd0,
    PD_STANDBY    = 2'd1,
    PD_RECOVERING = 2'd2
  } pd_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pdg_hold.sv
// Capture-and-hold stage: passes the pins while live, otherwise shows the
// last value seen while live.
module pdg_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live,
  input  logic [W-1:0] pin,
  output logic [W-1:0] core
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= '0;
    else if (live)   held_q <= pin;
  end

  assign core = live ? pin : held_q;
endmodule

// File: rtl/pdg_seq.sv
// Standby/recovery sequencer with one shared recovery counter and a
// per-path threshold compare.
module pdg_seq
  import pdg_pkg::*;
#(
  parameter int unsigned IN_RECOV  = 3,
  parameter int unsigned OE_RECOV  = 3,
  parameter int unsigned CLK_RECOV = 4,
  parameter int unsigned OUT_RECOV = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd,
  output pd_state_e state,
  output logic      in_live,
  output logic      oe_live,
  output logic      clk_live,
  output logic      out_live
);
  localparam int unsigned DONE = max2(max2(IN_RECOV, OE_RECOV), max2(CLK_RECOV, OUT_RECOV));
  localparam int unsigned CW   = $clog2(DONE + 1);
  localparam int unsigned NPATH = 4;
  localparam int unsigned THR [NPATH] = '{IN_RECOV, OE_RECOV, CLK_RECOV, OUT_RECOV};

  pd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NPATH-1:0] live;

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    unique case (st_q)
      PD_ACTIVE: begin
        if (pd) st_d = PD_STANDBY;
      end
      PD_STANDBY: begin
        if (!pd) st_d = PD_RECOVERING;
      end
      PD_RECOVERING: begin
        if (pd)                               st_d = PD_STANDBY;
        else if (cnt_q == CW'(DONE - 1))      st_d = PD_ACTIVE;
        else                                  cnt_d = cnt_q + 1'b1;
      end
      default: st_d = PD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PD_ACTIVE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < NPATH; g++) begin : g_thr
    assign live[g] = (st_q == PD_ACTIVE) ||
                     ((st_q == PD_RECOVERING) && (cnt_q >= CW'(THR[g])));
  end

  assign state    = st_q;
  assign in_live  = live[0];
  assign oe_live  = live[1];
  assign clk_live = live[2];
  assign out_live = live[3];
endmodule

// File: rtl/pdg_width_mon.sv
// Measures each level of the power-down pin and flags short ones.
module pdg_width_mon
  import pdg_pkg::*;
#(
  parameter int unsigned MIN_HIGH = 4,
  parameter int unsigned MIN_LOW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  output logic viol
);
  localparam int unsigned SAT = max2(max2(MIN_HIGH, MIN_LOW), 1);
  localparam int unsigned PW  = $clog2(SAT + 1);

  logic          pd_q;
  logic [PW-1:0] len_q;
  logic          viol_q;
  logic          short_lvl;

  assign short_lvl = pd_q ? (len_q < PW'(MIN_HIGH)) : (len_q < PW'(MIN_LOW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      len_q  <= PW'(SAT);
      viol_q <= 1'b0;
    end else begin
      pd_q <= pd;
      if (pd != pd_q) begin
        len_q <= PW'(1);
        if (short_lvl) viol_q <= 1'b1;
      end else if (len_q != PW'(SAT)) begin
        len_q <= len_q + 1'b1;
      end
    end
  end

  assign viol = viol_q;
endmodule

// File: rtl/pd_standby_ctrl.sv
module pd_standby_ctrl
  import pdg_pkg::*;
#(
  parameter int unsigned N_IN      = 14,
  parameter int unsigned IN_RECOV  = 3,
  parameter int unsigned OE_RECOV  = 3,
  parameter int unsigned CLK_RECOV = 4,
  parameter int unsigned OUT_RECOV = 5,
  parameter int unsigned MIN_HIGH  = 4,
  parameter int unsigned MIN_LOW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_pin,
  input  logic [N_IN-1:0] pin_in,
  input  logic            pin_oe,
  input  logic            pin_clk,
  output logic [N_IN-1:0] core_in,
  output logic            core_oe,
  output logic            core_clk,
  output logic            out_valid,
  output logic [1:0]      pd_state,
  output logic            width_viol
);
  pd_state_e st;
  logic in_live, oe_live, clk_live, out_live;

  pdg_seq #(
    .IN_RECOV (IN_RECOV),
    .OE_RECOV (OE_RECOV),
    .CLK_RECOV(CLK_RECOV),
    .OUT_RECOV(OUT_RECOV)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd      (pd_pin),
    .state   (st),
    .in_live (in_live),
    .oe_live (oe_live),
    .clk_live(clk_live),
    .out_live(out_live)
  );

  pdg_hold #(.W(N_IN)) u_hold_in (
    .clk  (clk),
    .rst_n(rst_n),
    .live (in_live),
    .pin  (pin_in),
    .core (core_in)
  );

  pdg_hold #(.W(1)) u_hold_oe (
    .clk  (clk),
    .rst_n(rst_n),
    .live (oe_live),
    .pin  (pin_oe),
    .core (core_oe)
  );

  pdg_width_mon #(
    .MIN_HIGH(MIN_HIGH),
    .MIN_LOW (MIN_LOW)
  ) u_width (
    .clk  (clk),
    .rst_n(rst_n),
    .pd   (pd_pin),
    .viol (width_viol)
  );

  assign core_clk  = clk_live & pin_clk;
  assign out_valid = out_live;
  assign pd_state  = st;
endmodule

// File: rtl/pdg_checker.sv
module pdg_checker
  import pdg_pkg::*;
#(
  parameter int unsigned N_IN = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd_pin,
  input logic [N_IN-1:0] core_in,
  input logic            core_oe,
  input logic            core_clk,
  input logic            out_valid,
  input logic [1:0]      pd_state,
  input logic            width_viol
);
  AST_ENTER_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == PD_ACTIVE && pd_pin) |=> (pd_state == PD_STANDBY)); // R3
  AST_FROZEN_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == PD_STANDBY && $past(pd_state) == PD_STANDBY) |-> ($stable(core_in) && $stable(core_oe))); // R3
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == PD_STANDBY) |-> (!core_clk && !out_valid)); // R4
  AST_EXIT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == PD_STANDBY && !pd_pin) |=> (pd_state == PD_RECOVERING)); // R5
  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state != 2'd3)); // R5
  AST_ACTIVE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == PD_ACTIVE) |-> out_valid); // R7
  AST_REENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == PD_RECOVERING && pd_pin) |=> (pd_state == PD_STANDBY)); // R8
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    width_viol |=> width_viol); // R10
endmodule

bind pd_standby_ctrl pdg_checker #(.N_IN(N_IN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pd_pin    (pd_pin),
  .core_in   (core_in),
  .core_oe   (core_oe),
  .core_clk  (core_clk),
  .out_valid (out_valid),
  .pd_state  (pd_state),
  .width_viol(width_viol)
);

// File: tb/tb_pd_standby_ctrl.sv
`timescale 1ns/1ps
module tb_pd_standby_ctrl;
  localparam int N_IN = 14;
  localparam int IN_R = 3, OE_R = 3, CK_R = 4, OUT_R = 5;
  localparam int MIN_HI = 4, MIN_LO = 4;
  localparam int DONE = 5;
  localparam int SAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_pin = 1'b0;
  logic [N_IN-1:0] pin_in = '0;
  logic pin_oe = 1'b0, pin_clk = 1'b0;
  logic [N_IN-1:0] core_in;
  logic core_oe, core_clk, out_valid, width_viol;
  logic [1:0] pd_state;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference state
  int m_st, m_cnt, m_pw;
  logic [N_IN-1:0] m_hin;
  logic m_hoe, m_pdq, m_viol;

  always #2.5 clk = ~clk;

  pd_standby_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_clk(pin_clk), .core_in(core_in), .core_oe(core_oe),
    .core_clk(core_clk), .out_valid(out_valid), .pd_state(pd_state),
    .width_viol(width_viol)
  );

  function automatic bit live_at(int st, int cnt, int thr);
    return (st == 0) || (st == 2 && cnt >= thr);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_pw = SAT;
    m_hin = '0; m_hoe = 1'b0; m_pdq = 1'b0; m_viol = 1'b0;
  endtask

  task automatic compare_all();
    logic [N_IN-1:0] e_in;
    logic e_oe, e_ck, e_v;
    e_in = live_at(m_st, m_cnt, IN_R) ? pin_in : m_hin;
    e_oe = live_at(m_st, m_cnt, OE_R) ? pin_oe : m_hoe;
    e_ck = live_at(m_st, m_cnt, CK_R) ? pin_clk : 1'b0;
    e_v  = live_at(m_st, m_cnt, OUT_R);
    check("R2 R3 R8 core_in", 32'(core_in), 32'(e_in));
    check("R2 R3 core_oe", 32'(core_oe), 32'(e_oe));
    check("R4 R6 core_clk", 32'(core_clk), 32'(e_ck));
    check("R4 R6 R7 out_valid", 32'(out_valid), 32'(e_v));
    check("R5 R7 R8 pd_state", 32'(pd_state), 32'(m_st));
    check("R9 R10 width_viol", 32'(width_viol), 32'(m_viol));
  endtask

  task automatic model_edge(input logic pd);
    if (live_at(m_st, m_cnt, IN_R)) m_hin = pin_in;
    if (live_at(m_st, m_cnt, OE_R)) m_hoe = pin_oe;
    if (pd != m_pdq) begin
      if (m_pdq && m_pw < MIN_HI) m_viol = 1'b1;
      if (!m_pdq && m_pw < MIN_LO) m_viol = 1'b1;
      m_pw = 1;
    end else if (m_pw < SAT) m_pw++;
    m_pdq = pd;
    case (m_st)
      0: begin m_cnt = 0; if (pd) m_st = 1; end
      1: begin m_cnt = 0; if (!pd) m_st = 2; end
      default: begin
        if (pd) begin m_st = 1; m_cnt = 0; end
        else if (m_cnt == DONE - 1) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
    endcase
  endtask

  task automatic step(input logic pd);
    @(negedge clk);
    pd_pin  = pd;
    pin_in  = N_IN'($urandom);
    pin_oe  = 1'($urandom);
    pin_clk = 1'($urandom);
    #1 compare_all();
    @(posedge clk);
    model_edge(pd);
  endtask

  task automatic hold_level(input logic pd, input int n);
    for (int i = 0; i < n; i++) step(pd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pd_pin = 1'b0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 state", 32'(pd_state), 32'd0);
    check("R1 out_valid", 32'(out_valid), 32'd1);
    check("R1 width_viol", 32'(width_viol), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R2 pass-through while active
    hold_level(1'b0, 4);
    // R3 R4 long standby, then R5 R6 R7 full recovery
    hold_level(1'b1, 6);
    hold_level(1'b0, 8);
    // R8 coincidence: re-request on the edge where recovery would finish
    hold_level(1'b1, 5);
    hold_level(1'b0, DONE);
    step(1'b1);
    @(negedge clk); #1;
    check("R8 stays STANDBY on coincidence", 32'(pd_state), 32'd1);
    check("R8 out_valid low on coincidence", 32'(out_valid), 32'd0);
    hold_level(1'b1, 4);
    hold_level(1'b0, 8);
    // R9 short high pulse, sequence proceeds
    hold_level(1'b1, 2);
    hold_level(1'b0, 8);
    check("R9 short high flagged", 32'(width_viol), 32'd1);
    check("R9 sequence completed", 32'(pd_state), 32'd0);
    hold_level(1'b0, 10);
    check("R10 flag held", 32'(width_viol), 32'd1);
    do_reset();
    // R9 short low pulse after a high
    hold_level(1'b1, 5);
    hold_level(1'b0, 2);
    hold_level(1'b1, 5);
    hold_level(1'b0, 8);
    check("R9 short low flagged", 32'(width_viol), 32'd1);
    do_reset();
    // random pulse trains
    for (int seg = 0; seg < 400; seg++) begin
      hold_level(1'(seg % 2), 1 + int'($urandom_range(0, 8)));
    end
    hold_level(1'b0, 8);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule